// File: doc/BRIEF.md
# Display Memory Pointer Write Controller

This block stores display data bytes in a single-bit display memory of 9 rows by 102 columns. Each column drives one segment line and each row belongs to one backplane. A stored 1 turns the element on and a stored 0 turns it off. Two load strobes set the column and row parts of a write pointer. Every data byte that follows is spread over the memory according to the selected multiplex mode, beginning at the pointer, and the pointer then moves on by itself.

The mode sets how many rows one column takes, called L:

| Mode | Code | L |
|---|---|---|
| static | 0 | 1 |
| 1:2 | 1 | 2 |
| 1:4 | 2 | 4 |
| 1:6 | 3 | 6 |
| 1:8 | 4 | 8 |
| aliases of 1:8 | 5, 6, 7 | 8 |

A byte is walked most significant bit first. The walk goes down the rows of one column and then moves to the next column, so a byte fills one row over eight columns or a block of rows over fewer columns. Each byte is written at the clock edge on which it is presented; there is no waiting phase. A combinational row read port serves the scan logic, which fetches a whole row of 102 bits at once.

Top module: `dram_ptr_writer`

## Requirements
- R1: While reset is asserted, and after it is released, every memory bit is 0 and the pointer is at column 0, row 0.
- R2: rd_data_o bit c equals the stored bit at row rd_row_i and column c, with no clock delay. A rd_row_i of 9 or more returns all zeros.
- R3: A column strobe loads col_val_i and a row strobe loads row_val_i; both may load in the same cycle. If a data byte arrives in a cycle with either strobe, the byte is dropped and the memory is unchanged.
- R4: Each bit of a byte, MSB first, goes to the pointer position (X,Y). It is written only if X < 102 and Y < L. Then Y increments; when Y+1 >= L, Y returns to 0 and X advances to the next column.
- R5: Static mode (code 0, L=1) writes the byte across columns X..X+7 of row 0, and X advances by 8.
- R6: In 1:2 mode (code 1, L=2) a byte starting at row 0 fills 4 columns by 2 rows, and X advances by 4.
- R7: In 1:4 mode (code 2, L=4) a byte starting at row 0 fills 2 columns by 4 rows, and X advances by 2.
- R8: In 1:6 mode (code 3, L=6) bits that run past row 5 continue at row 0 of the next column. Starting at row 0, consecutive bytes advance X by 1, 1, 2 in turn, and the row offset is carried between bytes.
- R9: In 1:8 mode (code 4, L=8) a byte starting at row 0 fills rows 0..7 of one column. Codes 5 to 7 behave exactly like code 4.
- R10: A bit whose row is L or higher is discarded. Row 8 is never written.
- R11: After column 101, or after any column value of 101 or more, the next column is 0. A bit at a column of 102 or more is discarded.
- R12: A byte can be written on every clock cycle. Each write overwrites the old value with a 0 or a 1, and the memory does not change in a cycle with no data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_col_i | input | 1 | Load the column pointer from col_val_i |
| col_val_i | input | 7 | Column pointer load value |
| set_row_i | input | 1 | Load the row pointer from row_val_i |
| row_val_i | input | 4 | Row pointer load value |
| data_valid_i | input | 1 | A data byte is present on data_i |
| data_i | input | 8 | Display data byte, MSB placed first |
| mode_i | input | 3 | Multiplex mode code (see R4 to R9) |
| rd_row_i | input | 4 | Row index for the scan read port |
| rd_data_o | output | 102 | Contents of the selected row, bit c = column c |

## Verification
The table drives bytes in every mode code, including an alias code. The bytes are asymmetric, so swapping bit order, rows or columns shows up as a wrong pattern. A chain of four 1:6 bytes shows whether the row offset is carried across bytes and whether the column step alternates. Starting rows above zero and above L show whether bits continue in the next column and whether out-of-range bits are dropped. Column loads near and past 101 show the wrap, an all-zero byte shows that a write can clear bits, and a strobe in the same cycle as a byte shows that the strobe wins.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    MODE_STATIC = 3'd0,
    MODE_MUX2   = 3'd1,
    MODE_MUX4   = 3'd2,
    MODE_MUX6   = 3'd3,
    MODE_MUX8   = 3'd4
  } mux_mode_e;

  // Rows occupied per column for a mode code; unlisted codes act as 1:8.
  function automatic logic [3:0] rows_per_col(input logic [2:0] code);
    logic [3:0] lim;
    case (code)
      MODE_STATIC: lim = 4'd1;
      MODE_MUX2:   lim = 4'd2;
      MODE_MUX4:   lim = 4'd4;
      MODE_MUX6:   lim = 4'd6;
      default:     lim = 4'd8;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/dram_ptr_regs.sv
module dram_ptr_regs #(
  parameter int COL_W = 7,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_col_i,
  input  logic [COL_W-1:0] col_val_i,
  input  logic             set_row_i,
  input  logic [ROW_W-1:0] row_val_i,
  input  logic             adv_i,
  input  logic [COL_W-1:0] col_adv_i,
  input  logic [ROW_W-1:0] row_adv_i,
  output logic [COL_W-1:0] col_q,
  output logic [ROW_W-1:0] row_q
);

  logic [COL_W-1:0] col_d;
  logic [ROW_W-1:0] row_d;
  logic             ptr_en;

  // Load strobes take priority over the automatic advance.
  always_comb begin
    col_d  = col_q;
    row_d  = row_q;
    ptr_en = 1'b0;
    if (set_col_i || set_row_i) begin
      ptr_en = 1'b1;
      if (set_col_i) col_d = col_val_i;
      if (set_row_i) row_d = row_val_i;
    end else if (adv_i) begin
      ptr_en = 1'b1;
      col_d  = col_adv_i;
      row_d  = row_adv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (ptr_en) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

endmodule

// File: rtl/dram_ptr_walk.sv
module dram_ptr_walk #(
  parameter int NCOL   = 102,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [COL_W-1:0]              col_i,
  input  logic [ROW_W-1:0]              row_i,
  input  logic [ROW_W-1:0]              lim_i,
  output logic [BYTE_W-1:0][COL_W-1:0]  bit_col_o,
  output logic [BYTE_W-1:0][ROW_W-1:0]  bit_row_o,
  output logic [BYTE_W-1:0]             bit_ok_o,
  output logic [COL_W-1:0]              col_end_o,
  output logic [ROW_W-1:0]              row_end_o
);

  logic [COL_W-1:0] st_col [BYTE_W+1];
  logic [ROW_W-1:0] st_row [BYTE_W+1];

  assign st_col[0] = col_i;
  assign st_row[0] = row_i;

  // One stage per bit of the byte: place the bit, then step the position.
  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_step
    logic             row_wrap;
    logic [COL_W-1:0] col_step;

    assign row_wrap = ({1'b0, st_row[gi]} + (ROW_W+1)'(1)) >= {1'b0, lim_i};
    assign col_step = ({1'b0, st_col[gi]} >= (COL_W+1)'(NCOL - 1)) ? '0
                    : st_col[gi] + COL_W'(1);

    assign bit_col_o[gi] = st_col[gi];
    assign bit_row_o[gi] = st_row[gi];
    assign bit_ok_o[gi]  = ({1'b0, st_col[gi]} < (COL_W+1)'(NCOL))
                        && (st_row[gi] < lim_i);

    assign st_col[gi+1] = row_wrap ? col_step : st_col[gi];
    assign st_row[gi+1] = row_wrap ? '0 : st_row[gi] + ROW_W'(1);
  end

  assign col_end_o = st_col[BYTE_W];
  assign row_end_o = st_row[BYTE_W];

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int NCOL   = 102,
  parameter int NROW   = 9,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [BYTE_W-1:0][COL_W-1:0]  bit_col_i,
  input  logic [BYTE_W-1:0][ROW_W-1:0]  bit_row_i,
  input  logic [BYTE_W-1:0]             bit_ok_i,
  input  logic [BYTE_W-1:0]             bit_val_i,
  input  logic [ROW_W-1:0]              rd_row_i,
  output logic [NCOL-1:0]               rd_data_o,
  output logic [NROW*NCOL-1:0]          cells_o
);

  logic [NCOL-1:0] mem_q [NROW];

  for (genvar gr = 0; gr < NROW; gr++) begin : g_row
    logic [NCOL-1:0] row_d;
    logic            row_hit;
    logic            row_en;

    always_comb begin
      row_d   = mem_q[gr];
      row_hit = 1'b0;
      for (int i = 0; i < BYTE_W; i++) begin
        if (bit_ok_i[i] && (bit_row_i[i] == ROW_W'(gr))) begin
          row_d[bit_col_i[i]] = bit_val_i[i];
          row_hit             = 1'b1;
        end
      end
    end

    assign row_en = wr_en_i & row_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[gr] <= '0;
      end else if (row_en) begin
        mem_q[gr] <= row_d;
      end
    end

    assign cells_o[gr*NCOL +: NCOL] = mem_q[gr];
  end

  always_comb begin
    rd_data_o = '0;
    if ({1'b0, rd_row_i} < (ROW_W+1)'(NROW)) rd_data_o = mem_q[rd_row_i];
  end

endmodule

// File: rtl/dram_ptr_writer.sv
module dram_ptr_writer
  import dram_pkg::*;
#(
  parameter int NCOL   = 102,
  parameter int NROW   = 9,
  parameter int BYTE_W = 8,
  localparam int COL_W = $clog2(NCOL),
  localparam int ROW_W = $clog2(NROW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_col_i,
  input  logic [COL_W-1:0] col_val_i,
  input  logic             set_row_i,
  input  logic [ROW_W-1:0] row_val_i,
  input  logic             data_valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [2:0]       mode_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic [NCOL-1:0]  rd_data_o
);

  logic [1:0]                    rst_sync_q;
  logic                          rst_sync_n;
  logic [COL_W-1:0]              col_q;
  logic [ROW_W-1:0]              row_q;
  logic [ROW_W-1:0]              lim;
  logic                          cmd_any;
  logic                          wr_go;
  logic [BYTE_W-1:0][COL_W-1:0]  bit_col;
  logic [BYTE_W-1:0][ROW_W-1:0]  bit_row;
  logic [BYTE_W-1:0]             bit_ok;
  logic [BYTE_W-1:0]             bit_val;
  logic [COL_W-1:0]              col_end;
  logic [ROW_W-1:0]              row_end;
  logic [NROW*NCOL-1:0]          cells_flat;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign cmd_any = set_col_i | set_row_i;
  assign wr_go   = data_valid_i & ~cmd_any;
  assign lim     = ROW_W'(rows_per_col(mode_i));

  // Walk stage i carries data bit BYTE_W-1-i (MSB placed first).
  for (genvar gb = 0; gb < BYTE_W; gb++) begin : g_order
    assign bit_val[gb] = data_i[BYTE_W-1-gb];
  end

  dram_ptr_regs #(.COL_W(COL_W), .ROW_W(ROW_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_col_i (set_col_i),
    .col_val_i (col_val_i),
    .set_row_i (set_row_i),
    .row_val_i (row_val_i),
    .adv_i     (wr_go),
    .col_adv_i (col_end),
    .row_adv_i (row_end),
    .col_q     (col_q),
    .row_q     (row_q)
  );

  dram_ptr_walk #(.NCOL(NCOL), .COL_W(COL_W), .ROW_W(ROW_W), .BYTE_W(BYTE_W)) u_walk (
    .col_i     (col_q),
    .row_i     (row_q),
    .lim_i     (lim),
    .bit_col_o (bit_col),
    .bit_row_o (bit_row),
    .bit_ok_o  (bit_ok),
    .col_end_o (col_end),
    .row_end_o (row_end)
  );

  dram_cell_array #(.NCOL(NCOL), .NROW(NROW), .COL_W(COL_W), .ROW_W(ROW_W),
                    .BYTE_W(BYTE_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_go),
    .bit_col_i (bit_col),
    .bit_row_i (bit_row),
    .bit_ok_i  (bit_ok),
    .bit_val_i (bit_val),
    .rd_row_i  (rd_row_i),
    .rd_data_o (rd_data_o),
    .cells_o   (cells_flat)
  );

endmodule

// File: rtl/dram_ptr_writer_chk.sv
module dram_ptr_writer_chk #(
  parameter int NCOL  = 102,
  parameter int NROW  = 9,
  parameter int COL_W = 7,
  parameter int ROW_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 set_col_i,
  input logic                 set_row_i,
  input logic                 data_valid_i,
  input logic [2:0]           mode_i,
  input logic [ROW_W-1:0]     rd_row_i,
  input logic [NCOL-1:0]      rd_data_o,
  input logic [COL_W-1:0]     col_q,
  input logic [ROW_W-1:0]     row_q,
  input logic [NROW*NCOL-1:0] cells
);

  logic cmd;
  logic byte_in;
  assign cmd     = set_col_i | set_row_i;
  assign byte_in = data_valid_i & ~cmd;

  a_r1_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (col_q == '0 && row_q == '0));

  a_r2_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_row_i} >= (ROW_W+1)'(NROW)) |-> (rd_data_o == '0));

  a_r3_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_i && cmd) |=> $stable(cells));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid_i |=> $stable(cells));

  a_r11_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_in |=> ({1'b0, col_q} < (COL_W+1)'(NCOL)));

  a_r5_static_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && mode_i == 3'd0 && {1'b0, col_q} < (COL_W+1)'(NCOL - 8))
    |=> (col_q == $past(col_q) + COL_W'(8)) && row_q == '0);

  a_r6_mux2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && mode_i == 3'd1 && row_q == '0 && {1'b0, col_q} < (COL_W+1)'(NCOL - 4))
    |=> (col_q == $past(col_q) + COL_W'(4)) && row_q == '0);

  a_r7_mux4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && mode_i == 3'd2 && row_q == '0 && {1'b0, col_q} < (COL_W+1)'(NCOL - 2))
    |=> (col_q == $past(col_q) + COL_W'(2)) && row_q == '0);

  a_r8_mux6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && mode_i == 3'd3 && row_q == '0 && {1'b0, col_q} < (COL_W+1)'(NCOL - 2))
    |=> (col_q == $past(col_q) + COL_W'(1)) && row_q == ROW_W'(2));

endmodule

bind dram_ptr_writer dram_ptr_writer_chk #(
  .NCOL(NCOL), .NROW(NROW), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .set_col_i    (set_col_i),
  .set_row_i    (set_row_i),
  .data_valid_i (data_valid_i),
  .mode_i       (mode_i),
  .rd_row_i     (rd_row_i),
  .rd_data_o    (rd_data_o),
  .col_q        (col_q),
  .row_q        (row_q),
  .cells        (cells_flat)
);

// File: tb/dram_ptr_writer_bench.sv
`timescale 1ns/100ps
module dram_ptr_writer_bench;

  localparam int NCOL = 102;
  localparam int NROW = 9;

  // op: 0 = load column, 1 = load row, 2 = data byte
  typedef struct packed {
    logic [1:0] op;
    logic [2:0] mode;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 26;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 3'd0, 8'd10,  4'd3},  // R3
    '{2'd2, 3'd0, 8'hA5,  4'd5},  // R5 static
    '{2'd0, 3'd0, 8'd20,  4'd3},
    '{2'd2, 3'd1, 8'hC3,  4'd6},  // R6 1:2
    '{2'd2, 3'd1, 8'h6E,  4'd6},
    '{2'd0, 3'd0, 8'd30,  4'd3},
    '{2'd2, 3'd2, 8'h96,  4'd7},  // R7 1:4
    '{2'd0, 3'd0, 8'd40,  4'd3},
    '{2'd2, 3'd3, 8'hFF,  4'd8},  // R8 1:6 chain
    '{2'd2, 3'd3, 8'h81,  4'd8},
    '{2'd2, 3'd3, 8'hF0,  4'd8},
    '{2'd2, 3'd3, 8'h0F,  4'd8},
    '{2'd0, 3'd0, 8'd50,  4'd3},
    '{2'd2, 3'd4, 8'h5A,  4'd9},  // R9 1:8
    '{2'd2, 3'd6, 8'h3C,  4'd9},  // R9 alias code
    '{2'd0, 3'd0, 8'd60,  4'd3},
    '{2'd1, 3'd0, 8'd3,   4'd3},
    '{2'd2, 3'd2, 8'hFF,  4'd4},  // R4 start mid-column
    '{2'd0, 3'd0, 8'd70,  4'd3},
    '{2'd1, 3'd0, 8'd7,   4'd3},
    '{2'd2, 3'd2, 8'hFF,  4'd10}, // R10 start row above L
    '{2'd0, 3'd0, 8'd98,  4'd3},
    '{2'd2, 3'd0, 8'hFF,  4'd11}, // R11 wrap at 101
    '{2'd0, 3'd0, 8'd120, 4'd3},
    '{2'd2, 3'd0, 8'h0F,  4'd11}, // R11 column out of range
    '{2'd2, 3'd0, 8'h00,  4'd12}  // R12 clears bits
  };

  logic             clk;
  logic             rst_n;
  logic             set_col_i;
  logic [6:0]       col_val_i;
  logic             set_row_i;
  logic [3:0]       row_val_i;
  logic             data_valid_i;
  logic [7:0]       data_i;
  logic [2:0]       mode_i;
  logic [3:0]       rd_row_i;
  logic [NCOL-1:0]  rd_data_o;

  int tests;
  int fails;
  logic [NCOL-1:0] exp_mem [NROW];
  int exp_col;
  int exp_row;

  dram_ptr_writer u_dram_ptr_writer (
    .clk(clk), .rst_n(rst_n), .set_col_i(set_col_i), .col_val_i(col_val_i),
    .set_row_i(set_row_i), .row_val_i(row_val_i), .data_valid_i(data_valid_i),
    .data_i(data_i), .mode_i(mode_i), .rd_row_i(rd_row_i), .rd_data_o(rd_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int lim_of(input logic [2:0] m);
    case (m)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic model_clear();
    for (int r = 0; r < NROW; r++) exp_mem[r] = '0;
    exp_col = 0;
    exp_row = 0;
  endtask

  // R4 walk from the requirement text
  task automatic model_byte(input logic [2:0] m, input logic [7:0] b);
    int l;
    l = lim_of(m);
    for (int i = 7; i >= 0; i--) begin
      if (exp_col < NCOL && exp_row < l) exp_mem[exp_row][exp_col] = b[i];
      if (exp_row + 1 >= l) begin
        exp_row = 0;
        exp_col = (exp_col >= NCOL - 1) ? 0 : exp_col + 1;
      end else begin
        exp_row = exp_row + 1;
      end
    end
  endtask

  task automatic idle_inputs();
    set_col_i = 1'b0; set_row_i = 1'b0; data_valid_i = 1'b0;
    col_val_i = '0; row_val_i = '0; data_i = '0; mode_i = '0;
  endtask

  task automatic drive(input logic sc, input logic sr, input logic [7:0] v,
                       input logic dv, input logic [7:0] d, input logic [2:0] m);
    @(negedge clk);
    set_col_i = sc; set_row_i = sr;
    col_val_i = v[6:0]; row_val_i = v[3:0];
    data_valid_i = dv; data_i = d; mode_i = m;
  endtask

  task automatic settle();
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
  endtask

  task automatic check_rows(input string tag);
    for (int r = 0; r < NROW; r++) begin
      rd_row_i = 4'(r);
      #0.5;
      tests++;
      if (rd_data_o !== exp_mem[r]) begin
        fails++;
        $display("FAIL %s row %0d: got %h expected %h", tag, r, rd_data_o, exp_mem[r]);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    rd_row_i = '0;
    idle_inputs();
    do_reset();
    check_rows("R1 reset state");

    // Table walk; expected memory follows from R3..R12
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      v = VEC[k];
      case (v.op)
        2'd0: begin drive(1'b1, 1'b0, v.val, 1'b0, 8'h00, 3'd0); exp_col = int'(v.val[6:0]); end
        2'd1: begin drive(1'b0, 1'b1, v.val, 1'b0, 8'h00, 3'd0); exp_row = int'(v.val[3:0]); end
        default: begin drive(1'b0, 1'b0, 8'h00, 1'b1, v.val, v.mode); model_byte(v.mode, v.val); end
      endcase
      settle();
      check_rows($sformatf("R%0d vector %0d", v.req, k));
    end

    // R10: row 8 in 1:8 mode is discarded; next bytes continue at row 0
    drive(1'b1, 1'b1, 8'd8, 1'b0, 8'h00, 3'd0);
    exp_col = 8; exp_row = 8;
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hFF, 3'd4);
    model_byte(3'd4, 8'hFF);
    settle();
    check_rows("R10 row 8 dropped");

    // R3: strobe with data in the same cycle drops the byte
    drive(1'b1, 1'b0, 8'd5, 1'b1, 8'hFF, 3'd0);
    exp_col = 5;
    settle();
    check_rows("R3 strobe wins");
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'h99, 3'd0);
    model_byte(3'd0, 8'h99);
    settle();
    check_rows("R3 load then write");

    // R12 and R8: back-to-back bytes, one per cycle, 1:6 carry
    drive(1'b1, 1'b1, 8'd80, 1'b0, 8'h00, 3'd0);
    exp_col = 80; exp_row = 0;
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hB7, 3'd3); model_byte(3'd3, 8'hB7);
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'h4C, 3'd3); model_byte(3'd3, 8'h4C);
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hE1, 3'd3); model_byte(3'd3, 8'hE1);
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'h2D, 3'd1); model_byte(3'd1, 8'h2D);
    settle();
    check_rows("R12 back to back");

    // R2: out-of-range row read returns zeros
    for (int r = NROW; r < 16; r++) begin
      rd_row_i = 4'(r);
      #0.5;
      tests++;
      if (rd_data_o !== '0) begin
        fails++;
        $display("FAIL R2 oob row %0d: got %h expected 0", r, rd_data_o);
      end
    end

    // R1: reset mid-run clears memory and returns pointer home
    do_reset();
    check_rows("R1 reset clears memory");
    drive(1'b0, 1'b0, 8'h00, 1'b1, 8'hC6, 3'd0);
    model_byte(3'd0, 8'hC6);
    settle();
    check_rows("R1 pointer home after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule